// File: doc/BRIEF.md
# Transmit Byte Buffer with Collision Replay

This block sits between a memory-fetch engine and a frame transmitter. The fetch side pushes bytes, each with a parity bit and an end-of-frame marker, for as long as the block shows free space. The transmit side pulls bytes one at a time. A start flag tells the transmitter that enough bytes are waiting for it to begin sending.

The first bytes of the frame now being sent are not freed when they are read. They stay in storage until a fixed number of them have been read, or until the frame's final byte has been read. If the line reports a collision inside that window, the transmitter pulses the rewind input. The read position then jumps back to the frame's first byte, and the frame is replayed from local storage without fetching it again. Each byte is checked for even parity as it leaves the block.

Top module: `txbuf_rewind`

## Requirements
- R1: Bytes leave in the order they were accepted, each with its own data and parity. A read accepted at a clock edge drives rd_valid high, with the byte on rd_data, for exactly the following cycle.
- R2: A read request made while rd_avail is low is ignored. rd_valid stays low, and the read position does not move.
- R3: wr_req is high exactly while the sum of unread entries and retained entries is below DEPTH (80 by default). A write offered while wr_req is low is dropped, and that byte never appears on the read side.
- R4: start_ok is high exactly while the number of unread bytes is at least THRESH (8 by default).
- R5: par_err is high, together with rd_valid, when the number of ones across the eight data bits and the stored parity bit is odd. Otherwise it is low.
- R6: rd_last repeats, together with each byte it belongs to, the end-of-frame marker that was written with that byte.
- R7: Bytes read from the current frame remain occupied, for the purpose of wr_req, until KEEP (64 by default) of them have been read or the frame's end-marked byte has been read. At that point all of them are freed at once.
- R8: A rewind pulse given while fewer than KEEP bytes of the current frame have been read sends the read position back to the frame's first byte. Every byte of the frame becomes readable again, and rd_avail counts them.
- R9: A rewind pulse given after KEEP bytes of the current frame have been read is ignored. The next read continues where reading stopped.
- R10: When rewind is accepted in the same cycle as a read request, the read is not performed. rd_valid stays low, and the next read returns the frame's first byte.
- R11: After reset, wr_req is high, and rd_avail, start_ok, rd_valid and par_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Fetch side offers a byte |
| wr_data | input | DW | Byte offered |
| wr_par | input | 1 | Parity bit stored with the byte |
| wr_last | input | 1 | Byte is the final byte of its frame |
| wr_req | output | 1 | Free space exists; a write will be taken |
| rd_en | input | 1 | Transmit side pulls one byte |
| rewind | input | 1 | Collision: replay the current frame from its start |
| rd_valid | output | 1 | rd_data holds a byte read at the previous edge |
| rd_data | output | DW | Byte read |
| rd_last | output | 1 | End-of-frame marker of the byte read |
| par_err | output | 1 | Byte read fails the even-parity check |
| rd_avail | output | 1 | At least one unread byte is stored |
| start_ok | output | 1 | Unread bytes have reached the start threshold |

## Verification
The bench builds the block with its default values: 80 entries, a 64-byte replay window and a start threshold of 8. At these sizes a few hundred cycles are enough to fill the storage completely and to read a whole replay window. The bench then sees wr_req held low during 63 reads of a full buffer and return on the 64th, and it confirms that a rewind arriving after that point is ignored. A 12-byte table with two frames and mixed parity covers the ordering, the marker and the parity checks. Shorter directed sequences cover the threshold edge, an empty read, and a rewind that coincides with a read.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  // Advance a circular index that wraps at an arbitrary depth.
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/txbuf_mem.sv
module txbuf_mem #(
  parameter int W     = 9,
  parameter int DEPTH = 80,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);

  logic [W-1:0] ram [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) q <= ram[raddr];
  end

endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl #(
  parameter int DEPTH  = 80,
  parameter int KEEP   = 64,
  parameter int THRESH = 8,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int FW     = $clog2(KEEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          wr_last,
  input  logic          rd_en,
  input  logic          rewind,
  output logic          wr_acc,
  output logic [AW-1:0] wptr,
  output logic          rd_acc,
  output logic [AW-1:0] rptr,
  output logic          cur_last,
  output logic [CW-1:0] unread,
  output logic [CW-1:0] held,
  output logic          kept,
  output logic          full,
  output logic          start_ok
);

  logic [AW-1:0]    pin;        // first entry of the frame being read
  logic [FW-1:0]    frame_rd;   // bytes read from that frame, saturates at KEEP
  logic [DEPTH-1:0] eof_flag;   // end marker per entry, readable without latency
  logic             rw_acc;
  logic [AW-1:0]    wptr_inc, rptr_inc;
  logic [CW:0]      occupied;

  assign wptr_inc = AW'(txbuf_pkg::ptr_next(32'(wptr), DEPTH));
  assign rptr_inc = AW'(txbuf_pkg::ptr_next(32'(rptr), DEPTH));

  assign kept     = frame_rd < FW'(KEEP);
  assign held     = kept ? CW'(frame_rd) : '0;
  assign occupied = {1'b0, unread} + {1'b0, held};
  assign full     = occupied == (CW + 1)'(DEPTH);
  assign start_ok = unread >= CW'(THRESH);
  assign cur_last = eof_flag[rptr];

  assign wr_acc = wr_valid && !full;
  assign rw_acc = rewind && kept;
  assign rd_acc = rd_en && (unread != '0) && !rw_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      pin      <= '0;
      frame_rd <= '0;
      unread   <= '0;
      eof_flag <= '0;
    end else begin
      if (wr_acc) begin
        eof_flag[wptr] <= wr_last;
        wptr           <= wptr_inc;
      end
      if (rw_acc) begin
        rptr     <= pin;
        frame_rd <= '0;
      end else if (rd_acc) begin
        rptr <= rptr_inc;
        if (cur_last) begin
          frame_rd <= '0;
          pin      <= rptr_inc;
        end else if (kept) begin
          frame_rd <= frame_rd + FW'(1);
        end
      end
      unread <= unread + CW'(wr_acc) - CW'(rd_acc) + (rw_acc ? CW'(frame_rd) : '0);
    end
  end

endmodule

// File: rtl/txbuf_rdstage.sv
module txbuf_rdstage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic          last_in,
  input  logic [DW:0]   q,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [DW-1:0] rd_data,
  output logic          par_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= re;
      if (re) rd_last <= last_in;
    end
  end

  assign rd_data = q[DW-1:0];
  assign par_err = rd_valid && (^q);

endmodule

// File: rtl/txbuf_rewind.sv
module txbuf_rewind #(
  parameter int DW     = 8,
  parameter int DEPTH  = 80,
  parameter int KEEP   = 64,
  parameter int THRESH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_par,
  input  logic          wr_last,
  output logic          wr_req,
  input  logic          rd_en,
  input  logic          rewind,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          par_err,
  output logic          rd_avail,
  output logic          start_ok
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_acc, rd_acc, cur_last, kept, full;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] unread, held;
  logic [DW:0]   mem_q;

  txbuf_ctrl #(.DEPTH(DEPTH), .KEEP(KEEP), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_last(wr_last),
    .rd_en(rd_en), .rewind(rewind), .wr_acc(wr_acc), .wptr(wptr),
    .rd_acc(rd_acc), .rptr(rptr), .cur_last(cur_last), .unread(unread),
    .held(held), .kept(kept), .full(full), .start_ok(start_ok)
  );

  txbuf_mem #(.W(DW + 1), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata({wr_par, wr_data}),
    .re(rd_acc), .raddr(rptr), .q(mem_q)
  );

  txbuf_rdstage #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .re(rd_acc), .last_in(cur_last), .q(mem_q),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data), .par_err(par_err)
  );

  assign wr_req   = !full;
  assign rd_avail = unread != '0;

endmodule

// File: rtl/txbuf_rewind_chk.sv
module txbuf_rewind_chk #(
  parameter int DEPTH = 80,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          rewind,
  input logic          rd_avail,
  input logic          rd_valid,
  input logic          par_err,
  input logic          start_ok,
  input logic          kept,
  input logic [CW-1:0] unread,
  input logic [CW-1:0] held
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, unread} + {1'b0, held}) <= (CW + 1)'(DEPTH));

  assert_empty_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_avail && !rewind) |=> !rd_valid);

  assert_start_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> rd_avail);

  assert_parerr_with_valid_R5: assert property (@(posedge clk) disable iff (rst)
    par_err |-> rd_valid);

  assert_rewind_blocks_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rewind && kept) |=> !rd_valid);

endmodule

bind txbuf_rewind txbuf_rewind_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rewind(rewind), .rd_avail(rd_avail),
  .rd_valid(rd_valid), .par_err(par_err), .start_ok(start_ok), .kept(kept),
  .unread(unread), .held(held)
);

// File: tb/tb_txbuf_rewind.sv
`timescale 1ns/1ps
module tb_txbuf_rewind;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0, wr_par = 1'b0, wr_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0, rewind = 1'b0;
  logic       wr_req, rd_valid, rd_last, par_err, rd_avail, start_ok;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txbuf_rewind dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_par(wr_par), .wr_last(wr_last), .wr_req(wr_req), .rd_en(rd_en),
    .rewind(rewind), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .par_err(par_err), .rd_avail(rd_avail),
    .start_ok(start_ok)
  );

  typedef struct packed {
    logic       err;
    logic       last;
    logic       par;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5}, '{1'b1, 1'b0, 1'b1, 8'h3C},
    '{1'b0, 1'b0, 1'b1, 8'h01}, '{1'b1, 1'b0, 1'b0, 8'h01},
    '{1'b0, 1'b0, 1'b0, 8'hFF}, '{1'b0, 1'b0, 1'b1, 8'h7F},
    '{1'b0, 1'b1, 1'b0, 8'h00}, '{1'b1, 1'b0, 1'b0, 8'h80},
    '{1'b0, 1'b0, 1'b0, 8'h55}, '{1'b1, 1'b0, 1'b1, 8'hC3},
    '{1'b0, 1'b0, 1'b1, 8'hFE}, '{1'b0, 1'b1, 1'b1, 8'h10}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_valid = 0; rd_en = 0; rewind = 0; wr_last = 0;
    rst = 1;
    step(); step(); step();
    rst = 0;
  endtask

  task automatic push(logic [7:0] d, logic l);
    wr_valid = 1; wr_data = d; wr_par = ^d; wr_last = l;
    step();
    wr_valid = 0; wr_last = 0;
  endtask

  task automatic pull(string tag, logic [7:0] exp);
    rd_en = 1;
    step();
    rd_en = 0;
    chk({tag, " valid"}, 32'(rd_valid), 1);
    chk({tag, " data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    do_reset();
    step();
    // R11: reset state
    chk("R11 wr_req", 32'(wr_req), 1);
    chk("R11 rd_avail", 32'(rd_avail), 0);
    chk("R11 start_ok", 32'(start_ok), 0);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    chk("R11 par_err", 32'(par_err), 0);

    // Table walk: write all vectors, threshold checked on each write (R4)
    for (int i = 0; i < 12; i++) begin
      wr_valid = 1; wr_data = VEC[i].data; wr_par = VEC[i].par; wr_last = VEC[i].last;
      step();
      chk("R4 start_ok", 32'(start_ok), 32'((i + 1) >= 8));
    end
    wr_valid = 0; wr_last = 0;
    for (int i = 0; i < 12; i++) begin
      rd_en = 1;
      step();
      chk("R1 valid", 32'(rd_valid), 1);
      chk("R1 data", 32'(rd_data), 32'(VEC[i].data));
      chk("R6 last", 32'(rd_last), 32'(VEC[i].last));
      chk("R5 par_err", 32'(par_err), 32'(VEC[i].err));
    end
    rd_en = 0;
    step();
    chk("R1 valid drops", 32'(rd_valid), 0);
    chk("R1 drained", 32'(rd_avail), 0);

    // R2: read while empty has no effect
    rd_en = 1;
    step();
    rd_en = 0;
    chk("R2 valid", 32'(rd_valid), 0);
    push(8'h42, 1'b1);
    pull("R2 pointer kept", 8'h42);

    // R3 / R7 / R9: fill completely, retention window
    do_reset();
    for (int i = 0; i < 80; i++) push(8'(i), 1'b0);
    chk("R3 full", 32'(wr_req), 0);
    push(8'hEE, 1'b0);
    chk("R3 still full", 32'(wr_req), 0);
    for (int i = 0; i < 63; i++) begin
      pull("R7 read", 8'(i));
    end
    chk("R7 held after 63", 32'(wr_req), 0);
    pull("R7 read 64th", 8'd63);
    chk("R7 released", 32'(wr_req), 1);
    push(8'hDD, 1'b1);
    rewind = 1;
    step();
    rewind = 0;
    pull("R9 rewind ignored", 8'd64);
    for (int i = 65; i < 80; i++) pull("R3 tail", 8'(i));
    pull("R3 dropped byte absent", 8'hDD);
    chk("R3 drained", 32'(rd_avail), 0);

    // R8 / R10: rewind inside the window
    do_reset();
    for (int i = 0; i < 20; i++) push(8'(8'h10 + i), 1'b0);
    for (int i = 0; i < 10; i++) pull("R8 first pass", 8'(8'h10 + i));
    rewind = 1;
    step();
    rewind = 0;
    pull("R8 replay start", 8'h10);
    pull("R8 replay next", 8'h11);
    rd_en = 1; rewind = 1;
    step();
    rd_en = 0; rewind = 0;
    chk("R10 read suppressed", 32'(rd_valid), 0);
    for (int i = 0; i < 20; i++) pull("R8 full replay", 8'(8'h10 + i));
    chk("R8 count exact", 32'(rd_avail), 0);

    done = 1;
    report();
  end

endmodule